// File: doc/BRIEF.md
# Decoded RAM/ROM Memory Subsystem

This block is a small memory subsystem on a 10-bit byte address with an 8-bit data path. It contains four 128-byte RAM banks and one 512-byte read-only store. Each device is gated by its own pair of chip selects, one active-high and one active-low. A device is active only when the high select is 1 and the low select is 0. A bus-level select pair qualifies every device at once, and the address decoder forms the per-device pairs from it.

The top address bit chooses between the RAM group and the read-only store. In the RAM half, the next two bits pick one of the four banks through a 2-to-4 decode, and the low seven bits pick a byte inside the bank. In the upper half, the low nine bits index the read-only store. Its contents are computed from a seed parameter. The three-state data bus is modelled as a separate input, an output and an output-enable.

Top module: `memSubsys`

## Requirements
- R1: Unless `busCs` is 1 and `busCsN` is 0, no device is active: `dataOe` stays 0 and no RAM byte changes, whatever the strobes are.
- R2: With the bus selected, `rdEn`=0 and `wrEn`=0 keeps `dataOe` at 0 and writes nothing.
- R3: With the bus selected, `rstN` high, `rdEn`=0 and `wrEn`=1, the RAM byte at the address takes `dataIn` on the rising clock edge.
- R4: With the bus selected and `rdEn`=1, `dataOe` is 1 and `dataOut` shows the addressed byte in the same cycle, whatever `wrEn` is. In that case no write takes place.
- R5: When `addr[9]`=0, `addr[8:7]` picks RAM bank 0..3 and `addr[6:0]` picks the byte. The banks cover 0x000-0x07F, 0x080-0x0FF, 0x100-0x17F and 0x180-0x1FF, and each bank keeps its own contents.
- R6: When `addr[9]`=1, a read returns the read-only byte at offset k=`addr[8:0]`. Its value is (k*3 + ROM_SEED) mod 256, and ROM_SEED defaults to 0x5A.
- R7: A write cycle aimed at 0x200-0x3FF changes no stored byte in either region and does not assert `dataOe`.
- R8: Whenever `dataOe` is 0, `dataOut` is 0.
- R9: At most one device drives read data in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on the rising edge |
| rstN | input | 1 | Active-low reset; blocks writes while low |
| busCs | input | 1 | Active-high bus select |
| busCsN | input | 1 | Active-low bus select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 10 | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data; 0 when not driven |
| dataOe | output | 1 | Output enable (high means driving) |

## Verification
The checker verifies the following on every clock:
- the output-enable follows the select pair and the read strobe;
- the data output is zero while the bus is not driven;
- at most one device drives;
- read-only data matches its formula.

The stored state is only visible through later reads, so only the bench scenarios can show it. The bench writes, then tries forbidden writes with bad selects, an idle strobe, both strobes, or a read-only address, and reads the stored bytes back. It also reads at the bank edges 0x07F, 0x080, 0x1FF, 0x200 and 0x3FF to show that the decode is correct.

// File: rtl/memSubsysPkg.sv
package memSubsysPkg;
  localparam int NUM_BANKS = 4;
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic [NUM_BANKS-1:0] ramWr;
    logic [NUM_BANKS-1:0] ramRd;
    logic                 romRd;
  } strobes_t;

  // Read-only byte at offset k: (k*3 + seed) mod 256
  function automatic logic [DATA_W-1:0] romByte(input logic [15:0] k,
                                                input logic [DATA_W-1:0] seed);
    logic [15:0] acc;
    acc = (k * 16'd3) + {8'd0, seed};
    return acc[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/memCtrl.sv
module memCtrl
  import memSubsysPkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int RAM_AW  = 7
) (
  input  logic              rstN,
  input  logic              busCs,
  input  logic              busCsN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          strb
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int GRP_BIT = ADDR_W - 1;

  logic [BANK_W-1:0]    bankIdx;
  logic [NUM_BANKS-1:0] bankDec;
  logic [NUM_BANKS-1:0] ramCsHi;
  logic [NUM_BANKS-1:0] ramCsLo;
  logic                 romCsHi;
  logic                 romCsLo;

  assign bankIdx = addr[RAM_AW +: BANK_W];

  // 2-to-4 style one-hot decode of the bank field
  always_comb begin
    bankDec = '0;
    bankDec[bankIdx] = 1'b1;
  end

  // Per-device chip-select pairs: high select qualified by bus select,
  // low select raised by bus deselect or by the group bit
  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_ramSel
      assign ramCsHi[gi] = busCs & bankDec[gi];
      assign ramCsLo[gi] = busCsN | addr[GRP_BIT];
      // Truth table: active when hi=1, lo=0; RD wins over WR
      assign strb.ramRd[gi] = ramCsHi[gi] & ~ramCsLo[gi] & rdEn;
      assign strb.ramWr[gi] = ramCsHi[gi] & ~ramCsLo[gi] & ~rdEn & wrEn & rstN;
    end
  endgenerate

  assign romCsHi    = busCs & addr[GRP_BIT];
  assign romCsLo    = busCsN;
  // Read-only store honours only the read strobe
  assign strb.romRd = romCsHi & ~romCsLo & rdEn;
endmodule

// File: rtl/memData.sv
module memData
  import memSubsysPkg::*;
#(
  parameter int              RAM_AW   = 7,
  parameter int              ROM_AW   = 9,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'h5A
) (
  input  logic              clk,
  input  strobes_t          strb,
  input  logic [RAM_AW-1:0] ramAddr,
  input  logic [ROM_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [NUM_BANKS-1:0][DATA_W-1:0] bankQ;
  logic [DATA_W-1:0]                romQ;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic [DATA_W-1:0] mem [0:RAM_DEPTH-1];
      always_ff @(posedge clk) begin
        if (strb.ramWr[gb]) mem[ramAddr] <= dataIn;
      end
      assign bankQ[gb] = mem[ramAddr];
    end
  endgenerate

  assign romQ = romByte({{(16-ROM_AW){1'b0}}, romAddr}, ROM_SEED);

  // AND-OR output mux; only an enabled device contributes
  always_comb begin
    dataOut = romQ & {DATA_W{strb.romRd}};
    for (int i = 0; i < NUM_BANKS; i++) begin
      dataOut = dataOut | (bankQ[i] & {DATA_W{strb.ramRd[i]}});
    end
  end

  assign dataOe = (|strb.ramRd) | strb.romRd;
endmodule

// File: rtl/memSubsys.sv
module memSubsys
  import memSubsysPkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                RAM_AW   = 7,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCs,
  input  logic              busCsN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int ROM_AW = ADDR_W - 1;

  strobes_t strb;

  memCtrl #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_ctrl (
    .rstN   (rstN),
    .busCs  (busCs),
    .busCsN (busCsN),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .strb   (strb)
  );

  memData #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .ROM_SEED(ROM_SEED)) u_data (
    .clk     (clk),
    .strb    (strb),
    .ramAddr (addr[RAM_AW-1:0]),
    .romAddr (addr[ROM_AW-1:0]),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );
endmodule

// File: rtl/memSubsysChk.sv
module memSubsysChk
  import memSubsysPkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'h5A
) (
  input logic              clk,
  input logic              rstN,
  input logic              busCs,
  input logic              busCsN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input strobes_t          strb
);
  logic busOn;
  assign busOn = busCs & ~busCsN;

  // R1
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busOn |-> !dataOe);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !dataOe);
  // R4
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOn && rdEn) |-> dataOe);
  // R6
  rom_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOn && rdEn && addr[ADDR_W-1]) |->
      dataOut == romByte({{(17-ADDR_W){1'b0}}, addr[ADDR_W-2:0]}, ROM_SEED));
  // R8
  oe_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);
  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ramRd, strb.romRd}));
  // R7
  rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    addr[ADDR_W-1] |-> strb.ramWr == '0);
endmodule

bind memSubsys memSubsysChk #(.ADDR_W(ADDR_W), .ROM_SEED(ROM_SEED)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busCs   (busCs),
  .busCsN  (busCsN),
  .rdEn    (rdEn),
  .addr    (addr),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .strb    (strb)
);

// File: tb/tb_memSubsys.sv
module tb_memSubsys;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busCs = 1'b0;
  logic       busCsN = 1'b1;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [0:511];

  always #5 clk = ~clk;

  memSubsys dut (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busCsN(busCsN),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [7:0] romExp(input int k);
    return 8'((k * 3 + 'h5A) % 256);
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One write-style cycle with arbitrary selects and strobes
  task automatic cycle(input logic [9:0] a, input logic [7:0] d,
                       input logic cs, input logic csN, input logic rd, input logic wr);
    @(negedge clk);
    addr = a; dataIn = d; busCs = cs; busCsN = csN; rdEn = rd; wrEn = wr;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; busCs = 1'b0; busCsN = 1'b1;
  endtask

  task automatic ramWrite(input logic [9:0] a, input logic [7:0] d);
    cycle(a, d, 1'b1, 1'b0, 1'b0, 1'b1);
    model[a[8:0]] = d;
  endtask

  task automatic readCheck(input string req, input logic [9:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; busCs = 1'b1; busCsN = 1'b0; rdEn = 1'b1; wrEn = 1'b0;
    #1;
    check(req, {dataOe, dataOut}, {1'b1, exp});
    rdEn = 1'b0; busCs = 1'b0; busCsN = 1'b1;
  endtask

  task automatic testReset();
    #1;
    check("R2 reset oe", {8'd0, dataOe}, 9'd0);
    check("R8 reset data", {1'b0, dataOut}, 9'd0);
  endtask

  task automatic testBanks();
    // R5 each bank distinct, including bank edges
    logic [9:0] al [8] = '{10'h000, 10'h07F, 10'h080, 10'h0FF,
                           10'h100, 10'h17F, 10'h180, 10'h1FF};
    for (int i = 0; i < 8; i++) ramWrite(al[i], 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++) readCheck("R5 bank map", al[i], model[al[i][8:0]]);
    // R3 rewrite and readback
    ramWrite(10'h0A5, 8'hC3);
    readCheck("R3 write", 10'h0A5, 8'hC3);
    ramWrite(10'h0A5, 8'h3C);
    readCheck("R3 overwrite", 10'h0A5, 8'h3C);
  endtask

  task automatic testSelects();
    // R1 writes with bad select pairs do nothing
    cycle(10'h010, 8'hEE, 1'b0, 1'b0, 1'b0, 1'b1);
    cycle(10'h010, 8'hEE, 1'b0, 1'b1, 1'b0, 1'b1);
    cycle(10'h010, 8'hEE, 1'b1, 1'b1, 1'b0, 1'b1);
    readCheck("R1 bad select no write", 10'h010, model[9'h010]);
    @(negedge clk);
    addr = 10'h010; busCs = 1'b1; busCsN = 1'b1; rdEn = 1'b1;
    #1;
    check("R1 bad select no drive", {dataOe, dataOut}, 9'd0);
    busCs = 1'b0; rdEn = 1'b0;
  endtask

  task automatic testIdle();
    @(negedge clk);
    addr = 10'h080; busCs = 1'b1; busCsN = 1'b0; dataIn = 8'h99;
    #1;
    check("R2 idle no drive", {dataOe, dataOut}, 9'd0);
    @(negedge clk);
    busCs = 1'b0; busCsN = 1'b1;
    readCheck("R2 idle no write", 10'h080, model[9'h080]);
  endtask

  task automatic testBoth();
    @(negedge clk);
    addr = 10'h100; dataIn = 8'h77; busCs = 1'b1; busCsN = 1'b0; rdEn = 1'b1; wrEn = 1'b1;
    #1;
    check("R4 read with wr high", {dataOe, dataOut}, {1'b1, model[9'h100]});
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; busCs = 1'b0; busCsN = 1'b1;
    readCheck("R4 no write when rd", 10'h100, model[9'h100]);
  endtask

  task automatic testRom();
    int offs [5] = '{0, 1, 85, 300, 511};
    foreach (offs[i]) readCheck("R6 rom value", 10'(10'h200 + offs[i]), romExp(offs[i]));
    // R7 write into rom range
    @(negedge clk);
    addr = 10'h205; dataIn = 8'h00; busCs = 1'b1; busCsN = 1'b0; wrEn = 1'b1;
    #1;
    check("R7 rom write no drive", {dataOe, dataOut}, 9'd0);
    @(negedge clk);
    wrEn = 1'b0; busCs = 1'b0; busCsN = 1'b1;
    readCheck("R7 rom unchanged", 10'h205, romExp(5));
    readCheck("R7 ram alias unchanged", 10'h005, model[9'h005]);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // preload a byte that aliases the rom probe
    ramWrite(10'h005, 8'h5E);
    ramWrite(10'h010, 8'h42);
    testBanks();
    testSelects();
    testIdle();
    testBoth();
    testRom();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule